// File: doc/BRIEF.md
# Duplicated Substitution Pipeline with Freeze-on-Disagreement

This block is a three-stage byte substitution pipeline in which every stage carries two identical copies of its combinational logic. Both copies read the same stage register, and a comparator checks their results on every cycle. If any occupied stage sees its two copies disagree, the whole pipeline holds. Every stage register and the output register keep their contents, the output-valid strobe stays low and the upstream ready is withdrawn. When the copies agree again, the pipeline moves on by itself. A short upset is therefore masked by waiting, and nothing is rolled back or recomputed.

The input side is a valid/ready byte stream. The output side is a valid-qualified byte with no back-pressure. A combinational fault line reports every cycle with a disagreement. A sticky flag reports a disagreement that has lasted long enough to look permanent. A per-stage injection mask lets a test corrupt the second copy of any stage.

Top module: `freeze_dup_pipe`

## Requirements
- R1: For an input byte x, the output is S2(S1(S0(x))), where S0(v) = rotate-left-by-1(v) XOR 0x5A, S1(v) = (v + 0x3C) mod 256, and S2(v) = rotate-left-by-3(v) XOR 0xA5. With no disagreement, out_valid is high in the cycle that follows the third rising edge after the capture edge.
- R2: Each accepted byte leaves exactly once, in acceptance order, with out_valid high for one cycle per byte.
- R3: Bits [8s+7:8s] of inj_mask are XORed into the result of the second copy of stage s only. Stage 0 is the first stage after the input register. The value passed forward always comes from the first copy.
- R4: fault is high in every cycle in which a stage that holds valid data has copies that disagree. A mask applied to a stage that holds no data has no effect on fault, in_ready or the outputs.
- R5: After a cycle with fault high, out_valid is low and out_data is unchanged. Each disagreement cycle delays the byte by exactly one cycle, and the byte still comes out with its correct value once the copies agree.
- R6: in_ready is low in every cycle with fault high, so no byte offered upstream during a freeze is lost.
- R7: perm_fault sets at the end of the 17th consecutive disagreement cycle (more than 16 cycles). A run of 16 cycles does not set it. Once set, it stays high until reset.
- R8: While rst_n is low, out_valid, out_data, fault, perm_fault and in_ready are all 0. in_ready rises after two rising edges following the release of rst_n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Pipeline can take a byte this cycle |
| in_data | input | 8 | Input byte |
| inj_mask | input | 24 | Per-stage XOR mask applied to the second copy (8 bits per stage) |
| out_valid | output | 1 | out_data carries a new result this cycle |
| out_data | output | 8 | Substituted byte, held during a freeze |
| fault | output | 1 | Copies of some occupied stage disagree this cycle |
| perm_fault | output | 1 | Sticky: a disagreement lasted more than 16 cycles |

## Verification
The assertions assume that a disagreement comes only from inj_mask. They also assume that inj_mask changes away from the clock edge, so the fault line and in_ready are settled when they are sampled. The stimulus drives inj_mask and the input handshake at the falling edge only. The table-driven part keeps one byte in flight, so every freeze window lines up with a known stage. The streaming part places a three-cycle freeze in the middle of a back-to-back burst to check ordering and that no byte is lost.

// File: rtl/dmr_pipe_pkg.sv
package dmr_pipe_pkg;
  localparam int DW          = 8;
  localparam int STAGES      = 3;
  localparam int STUCK_LIMIT = 16;

  localparam logic [DW-1:0] KEY_A = 8'h5A;
  localparam logic [DW-1:0] KEY_B = 8'h3C;
  localparam logic [DW-1:0] KEY_C = 8'hA5;
endpackage

// File: rtl/dsp_rst_sync.sv
module dsp_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/dsp_stage_copy.sv
module dsp_stage_copy
  import dmr_pipe_pkg::*;
#(
  parameter int STAGE_IDX = 0
) (
  input  logic [DW-1:0] x,
  output logic [DW-1:0] y
);
  generate
    if (STAGE_IDX == 0) begin : g_rot_xor
      assign y = {x[DW-2:0], x[DW-1]} ^ KEY_A;
    end else if (STAGE_IDX == 1) begin : g_add
      assign y = x + KEY_B;
    end else begin : g_rot3_xor
      assign y = {x[DW-4:0], x[DW-1:DW-3]} ^ KEY_C;
    end
  endgenerate
endmodule

// File: rtl/dsp_dup_stage.sv
module dsp_dup_stage
  import dmr_pipe_pkg::*;
#(
  parameter int STAGE_IDX = 0
) (
  input  logic [DW-1:0] d,
  input  logic          vld,
  input  logic [DW-1:0] inj,
  output logic [DW-1:0] y,
  output logic          mismatch
);
  logic [DW-1:0] y_a;
  logic [DW-1:0] y_b_raw;
  logic [DW-1:0] y_b;

  dsp_stage_copy #(.STAGE_IDX(STAGE_IDX)) u_copy_a (.x(d), .y(y_a));
  dsp_stage_copy #(.STAGE_IDX(STAGE_IDX)) u_copy_b (.x(d), .y(y_b_raw));

  assign y_b      = y_b_raw ^ inj;
  assign y        = y_a;
  assign mismatch = vld & (y_a != y_b);
endmodule

// File: rtl/dsp_persist_mon.sv
module dsp_persist_mon #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mis,
  output logic stuck
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] run_q, run_n;
  logic          stuck_q, stuck_n;
  logic          at_limit;

  assign at_limit = (run_q == CW'(LIMIT));

  always_comb begin
    run_n   = run_q;
    stuck_n = stuck_q;
    if (mis) begin
      if (!at_limit) run_n = run_q + 1'b1;
      if (at_limit)  stuck_n = 1'b1;
    end else begin
      run_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      stuck_q <= 1'b0;
    end else begin
      run_q   <= run_n;
      stuck_q <= stuck_n;
    end
  end

  assign stuck = stuck_q;
endmodule

// File: rtl/freeze_dup_pipe.sv
module freeze_dup_pipe
  import dmr_pipe_pkg::*;
#(
  parameter int NS         = STAGES,
  parameter int PERM_LIMIT = STUCK_LIMIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  input  logic [NS*DW-1:0] inj_mask,
  output logic             out_valid,
  output logic [DW-1:0]    out_data,
  output logic             fault,
  output logic             perm_fault
);
  logic          rst_ok_n;
  logic [DW-1:0] stg_d_q [NS];
  logic [DW-1:0] stg_d_n [NS];
  logic [NS-1:0] stg_v_q, stg_v_n, stg_d_en;
  logic [DW-1:0] stg_y   [NS];
  logic [NS-1:0] stg_mis;
  logic          any_mis, advance;
  logic          out_v_q, out_v_n, out_d_en;
  logic [DW-1:0] out_d_q, out_d_n;

  dsp_rst_sync u_rst_sync (.clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_ok_n));

  generate
    for (genvar s = 0; s < NS; s++) begin : g_stage
      dsp_dup_stage #(.STAGE_IDX(s)) u_stage (
        .d        (stg_d_q[s]),
        .vld      (stg_v_q[s]),
        .inj      (inj_mask[s*DW +: DW]),
        .y        (stg_y[s]),
        .mismatch (stg_mis[s])
      );
    end
  endgenerate

  always_comb begin
    any_mis = |stg_mis;
    advance = rst_ok_n & ~any_mis;
    for (int s = 0; s < NS; s++) begin
      if (s == 0) begin
        stg_d_n[s] = in_data;
        stg_v_n[s] = in_valid;
      end else begin
        stg_d_n[s] = stg_y[s-1];
        stg_v_n[s] = stg_v_q[s-1];
      end
      stg_d_en[s] = advance & stg_v_n[s];
    end
    out_d_n  = stg_y[NS-1];
    out_v_n  = advance & stg_v_q[NS-1];
    out_d_en = out_v_n;
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      for (int s = 0; s < NS; s++) stg_d_q[s] <= '0;
      stg_v_q <= '0;
      out_v_q <= 1'b0;
      out_d_q <= '0;
    end else begin
      for (int s = 0; s < NS; s++) begin
        if (stg_d_en[s]) stg_d_q[s] <= stg_d_n[s];
      end
      if (advance)  stg_v_q <= stg_v_n;
      out_v_q <= out_v_n;
      if (out_d_en) out_d_q <= out_d_n;
    end
  end

  dsp_persist_mon #(.LIMIT(PERM_LIMIT)) u_persist (
    .clk   (clk),
    .rst_n (rst_ok_n),
    .mis   (any_mis),
    .stuck (perm_fault)
  );

  assign in_ready  = advance;
  assign fault     = any_mis;
  assign out_valid = out_v_q;
  assign out_data  = out_d_q;
endmodule

// File: rtl/freeze_dup_pipe_chk.sv
module freeze_dup_pipe_chk #(
  parameter int LIMIT = 16,
  parameter int DW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic [DW-1:0] out_data,
  input logic          fault,
  input logic          perm_fault
);
  localparam int CW = $clog2(LIMIT + 2) + 1;
  logic [CW-1:0] streak;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          streak <= '0;
    else if (!fault)                     streak <= '0;
    else if (streak != CW'(LIMIT + 1))   streak <= streak + 1'b1;
  end

  // R5
  freeze_holds_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!out_valid && $stable(out_data)));

  // R6
  ready_low_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !in_ready);

  // R7
  perm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perm_fault |=> perm_fault);

  // R7
  perm_needs_long_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perm_fault) |-> (streak > CW'(LIMIT)));

  // R7
  long_run_sets_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (streak > CW'(LIMIT)) |-> perm_fault);
endmodule

bind freeze_dup_pipe freeze_dup_pipe_chk #(.LIMIT(PERM_LIMIT), .DW(dmr_pipe_pkg::DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .fault      (fault),
  .perm_fault (perm_fault)
);

// File: tb/freeze_dup_pipe_tb.sv
module freeze_dup_pipe_tb;
  localparam int CLK_P = 10;
  localparam int NV    = 8;
  // {data, stage, mask, freeze cycles}
  localparam logic [31:0] VEC [NV] = '{
    {8'h00, 8'd0, 8'h00, 8'd0},
    {8'hFF, 8'd0, 8'h00, 8'd0},
    {8'h3C, 8'd0, 8'h01, 8'd1},
    {8'h81, 8'd1, 8'h80, 8'd2},
    {8'h7E, 8'd2, 8'hFF, 8'd3},
    {8'hC4, 8'd1, 8'h10, 8'd1},
    {8'h55, 8'd2, 8'h01, 8'd16},
    {8'hAA, 8'd0, 8'h40, 8'd17}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_data;
  logic [23:0] inj_mask;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        fault;
  logic        perm_fault;

  int total = 0;
  int fails = 0;
  bit exp_perm = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  freeze_dup_pipe u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .inj_mask(inj_mask), .out_valid(out_valid),
    .out_data(out_data), .fault(fault), .perm_fault(perm_fault)
  );

  function automatic logic [7:0] ref_sub(input logic [7:0] x);
    logic [7:0] a, b;
    a = {x[6:0], x[7]} ^ 8'h5A;
    b = a + 8'h3C;
    return {b[4:0], b[7:5]} ^ 8'hA5;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_item(input logic [7:0] d, input int stg, input logic [7:0] m, input int dur);
    int n;
    logic [7:0] held;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    #1;
    check(in_ready == 1'b1, "R6 ready while idle", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    n = 1;
    while (n < 1 + stg) begin @(negedge clk); n++; end
    held = out_data;
    for (int k = 0; k < dur; k++) begin
      inj_mask = 24'(m) << (8 * stg);
      #1;
      check(fault == 1'b1, "R4 fault on disagreement", fault, 1);
      check(in_ready == 1'b0, "R6 ready low during freeze", in_ready, 0);
      check(out_valid == 1'b0 && out_data == held, "R5 output held", {out_valid, out_data}, {1'b0, held});
      @(negedge clk);
      n++;
    end
    inj_mask = '0;
    while (!out_valid && n < 60) begin @(negedge clk); n++; end
    check(out_valid == 1'b1 && out_data == ref_sub(d), "R1 R3 result value", out_data, ref_sub(d));
    check(n == 4 + dur, "R1 R5 latency", n, 4 + dur);
    @(negedge clk);
    check(out_valid == 1'b0, "R2 single output pulse", out_valid, 0);
    if (dur > 16) exp_perm = 1'b1;
    check(perm_fault == exp_perm, "R7 persistent flag", perm_fault, exp_perm);
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] sdat [6];
    int got;
    bit saw_stall;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; inj_mask = '0;
    repeat (3) @(negedge clk);
    // R8 reset state
    check({out_valid, out_data, fault, perm_fault, in_ready} == '0, "R8 reset state",
          {out_valid, out_data, fault, perm_fault, in_ready}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(in_ready == 1'b1, "R8 ready after release", in_ready, 1);

    // R4: mask on empty pipeline is ignored
    inj_mask = '1;
    #1;
    check(fault == 1'b0 && in_ready == 1'b1, "R4 empty-stage mask ignored", {fault, in_ready}, 2'b01);
    @(negedge clk);
    check(out_valid == 1'b0 && fault == 1'b0, "R4 no output from empty mask", {out_valid, fault}, 0);
    inj_mask = '0;

    for (int i = 0; i < NV; i++) begin
      run_item(VEC[i][31:24], int'(VEC[i][23:16]), VEC[i][15:8], int'(VEC[i][7:0]));
    end

    // R7: flag survives until reset; R8: reset clears it
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(perm_fault == 1'b0 && in_ready == 1'b0, "R8 R7 reset clears flag", {perm_fault, in_ready}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2 R6: streaming burst with a freeze in the middle
    for (int i = 0; i < 6; i++) sdat[i] = 8'(8'h13 + 8'h29 * i);
    got = 0;
    saw_stall = 1'b0;
    fork
      begin
        for (int i = 0; i < 6; i++) begin
          @(negedge clk);
          in_valid = 1'b1;
          in_data  = sdat[i];
          #2;
          while (!in_ready) begin
            saw_stall = 1'b1;
            @(negedge clk);
            #2;
          end
        end
        @(negedge clk);
        in_valid = 1'b0;
      end
      begin
        repeat (4) @(negedge clk);
        inj_mask = 24'h000800;
        repeat (3) @(negedge clk);
        inj_mask = '0;
      end
      begin
        for (int c = 0; c < 40; c++) begin
          @(negedge clk);
          #3;
          if (out_valid) begin
            if (got < 6)
              check(out_data == ref_sub(sdat[got]), "R2 stream order and value", out_data, ref_sub(sdat[got]));
            got++;
          end
        end
      end
    join
    check(got == 6, "R2 every byte exactly once", got, 6);
    check(saw_stall == 1'b1, "R6 ready withheld in burst", saw_stall, 1);
    check(perm_fault == 1'b0, "R7 short freeze leaves flag clear", perm_fault, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule